// File: doc/BRIEF.md
# SPI Command Packet Peripheral Slave

This block is an SPI slave that gives a host master access to a small set of peripheral services through fixed three-byte packets. The host sends a command byte, a data byte and a filler byte. In the same three byte slots the slave shifts back a status byte, the command it just received, and a response byte. The services are:

- a pair of 32-entry byte queues toward a serial line, one for transmit and one for receive;
- a 128-byte nonvolatile-style store with a write key and a modelled write-busy time;
- a readback of three mode jumpers;
- a keyed system reset request;
- a version query.

The status byte shifted out first describes the block as it stood when the previous packet finished, not as it stands now. Framing is held by a byte-position counter that survives select deassertion. A run of three `0x0F` bytes puts that counter back to the start of a packet, whatever position it was in. The serial-line side sees the transmit queue as a pop port and the receive queue as a push port. The baud divisor and the watchdog period that the host writes are brought out as plain register outputs.

Top module: `spi_cmd_slave`

## Requirements
- R1: SPI mode 0 with MSB first. Each packet returns the status byte, then an echo of the command byte, then the response byte. Commands without a defined response return `0x00` in the third slot.
- R2: The status byte reflects state latched when the previous packet's third byte completed (or at a resync). Changes between packets do not alter it. After reset it is `0x00`.
- R3: Status bit layout:
  - bit 0: receive queue not empty
  - bit 1: transmit queue not full
  - bit 4: receive overrun
  - bit 6: store busy
  - bit 7: the `wdog_reset_flag` input
  - bits 2, 3 and 5 are zero.
- R4: The command codes are listed below. Codes `0x0C`, `0x0E` and anything above `0x0F` act as no-ops with response `0x00`.

  | Code | Action |
  |------|--------|
  | `0x00` | no-op |
  | `0x03` | returns `VERSION` |
  | `0x04` | loads `baud_div` from the data byte |
  | `0x07` | loads `wdog_period` from the data byte |
  | `0x0F` | no-op |
- R5: Command `0x01` pushes the data byte into the 32-entry transmit queue. The byte is dropped when the queue is full. The serial side pops the queue in order through `ser_tx_take`.
- R6: Command `0x02` pops the 32-entry receive queue and returns the popped byte. On an empty queue it returns `0x00` and changes nothing. A serial-side push into a full receive queue is dropped and sets the overrun flag.
- R7: Command `0x08` empties both queues and clears the overrun flag.
- R8: The store address pointer is 7 bits (`0x00`–`0x7F`):
  - command `0x05` loads it from data bits 6:0;
  - command `0x0D` returns the byte at the pointer;
  - command `0x06` writes the byte at the pointer;
  - every read, and every accepted write, advances the pointer by one, wrapping from `0x7F` to `0x00`.
- R9: Command `0x09` enables store writes only with data `0x42`; any other data value disables them. Writes while disabled are ignored. An accepted system reset command also disables them.
- R10: An accepted store write holds store busy for `BUSY_CYC` clock cycles. Writes arriving while busy are ignored and leave the pointer unchanged.
- R11: Command `0x0B` returns `0xA0` OR'd with the 3-bit `mode_pins` value.
- R12: Command `0x0A` with data `0xC4` raises `sys_reset_req` for exactly one cycle. With any other data it does nothing.
- R13: Three consecutive received `0x0F` bytes force the next byte to be taken as the command byte of a new packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | master-to-slave data |
| spi_miso | output | 1 | slave-to-master data |
| mode_pins | input | 3 | mode jumper value for readback |
| wdog_reset_flag | input | 1 | last reset came from the watchdog |
| ser_tx_data | output | 8 | head of the transmit queue |
| ser_tx_avail | output | 1 | transmit queue holds a byte |
| ser_tx_take | input | 1 | pop the transmit queue head |
| ser_rx_data | input | 8 | byte received from the serial line |
| ser_rx_put | input | 1 | push `ser_rx_data` into the receive queue |
| baud_div | output | 8 | baud divisor written by the host |
| wdog_period | output | 8 | watchdog period written by the host |
| sys_reset_req | output | 1 | one-cycle system reset request |

## Verification
The SPI pins pass through a two-stage synchronizer. A completed byte therefore takes effect about four clock cycles after its eighth rising `spi_sclk` edge, and the next byte to shift out is loaded then. The bench holds each `spi_sclk` phase for eight clock cycles and samples `spi_miso` at its own rising `spi_sclk` edges, which gives the loaded byte margin. A command acts at the completion of its data byte, and the status byte is latched at the completion of the third byte. The expected status is therefore fixed in the model at packet end, and queue or jumper changes made between packets are left out of it. Store busy spans 700 cycles in the bench. One packet lasts about 420 cycles, so a write in the packet right after an accepted write lands inside the busy window, and one two packets later lands outside it. Accepted writes in the random phase are followed by a long idle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_QWRITE  = 8'h01;
    localparam logic [7:0] OP_QREAD   = 8'h02;
    localparam logic [7:0] OP_VERSION = 8'h03;
    localparam logic [7:0] OP_BAUD    = 8'h04;
    localparam logic [7:0] OP_SADDR   = 8'h05;
    localparam logic [7:0] OP_SWRITE  = 8'h06;
    localparam logic [7:0] OP_WDOG    = 8'h07;
    localparam logic [7:0] OP_SERRST  = 8'h08;
    localparam logic [7:0] OP_SWEN    = 8'h09;
    localparam logic [7:0] OP_SYSRST  = 8'h0A;
    localparam logic [7:0] OP_MODE    = 8'h0B;
    localparam logic [7:0] OP_SREAD   = 8'h0D;

    localparam logic [7:0] SYNC_BYTE  = 8'h0F;
    localparam logic [7:0] KEY_WEN    = 8'h42;
    localparam logic [7:0] KEY_RST    = 8'hC4;
    localparam logic [7:0] MODE_TAG   = 8'hA0;

    typedef enum logic [1:0] {
        SLOT_CMD  = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_TAIL = 2'd2
    } slot_e;

    typedef struct packed {
        logic wdog;
        logic busy;
        logic zero5;
        logic overrun;
        logic zero3;
        logic zero2;
        logic tx_space;
        logic rx_avail;
    } status_t;

    function automatic status_t pack_status(input logic rx_empty, input logic tx_full,
                                            input logic ovr, input logic busy,
                                            input logic wdog);
        status_t s;
        s          = '0;
        s.rx_avail = !rx_empty;
        s.tx_space = !tx_full;
        s.overrun  = ovr;
        s.busy     = busy;
        s.wdog     = wdog;
        return s;
    endfunction

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] load_byte,
    output logic       miso,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic [2:0] sclk_s;
    logic [1:0] cs_s;
    logic [1:0] mosi_s;
    logic [2:0] bit_cnt;
    logic       skip;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sel, rise, fall;

    assign sel  = !cs_s[1];
    assign rise = sel && sclk_s[1] && !sclk_s[2];
    assign fall = sel && !sclk_s[1] && sclk_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= '0;
            cs_s   <= 2'b11;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            skip    <= 1'b0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (done) begin
                tx_sh <= load_byte;
            end else if (fall) begin
                if (skip) skip <= 1'b0;
                else      tx_sh <= {tx_sh[6:0], 1'b0};
            end
            if (!sel) begin
                bit_cnt <= '0;
                skip    <= 1'b0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    done <= 1'b1;
                    skip <= 1'b1;
                end
            end
        end
    end

    assign miso    = tx_sh[7];
    assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                mem[wp[AW-1:0]] <= wdata;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter logic [7:0] VERSION     = 8'h13,
    parameter int         BUSY_CYC    = 1250000,
    parameter int         STORE_DEPTH = 128,
    localparam int        AW          = $clog2(STORE_DEPTH),
    localparam int        CW          = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exec,
    input  logic [7:0]    cmd,
    input  logic [7:0]    data,
    input  logic [2:0]    mode,
    input  logic [7:0]    rx_head,
    input  logic          rx_empty,
    input  logic          tx_full,
    output logic [7:0]    resp,
    output logic          tx_push,
    output logic          rx_pop,
    output logic          flush,
    output logic [7:0]    baud_div,
    output logic [7:0]    wdog_period,
    output logic          sys_reset_req,
    output logic          store_wr,
    output logic          store_busy,
    output logic          store_wen,
    output logic [AW-1:0] store_addr
);
    logic [7:0]    mem [STORE_DEPTH];
    logic [CW-1:0] busy_cnt;
    logic          store_rd;

    assign store_busy = (busy_cnt != '0);

    always_comb begin
        resp     = '0;
        tx_push  = 1'b0;
        rx_pop   = 1'b0;
        flush    = 1'b0;
        store_wr = 1'b0;
        store_rd = 1'b0;
        if (exec) begin
            case (cmd)
                OP_QWRITE:  tx_push = !tx_full;
                OP_QREAD:   if (!rx_empty) begin
                                rx_pop = 1'b1;
                                resp   = rx_head;
                            end
                OP_VERSION: resp = VERSION;
                OP_SWRITE:  store_wr = store_wen && !store_busy;
                OP_SERRST:  flush = 1'b1;
                OP_MODE:    resp = MODE_TAG | {5'b0, mode};
                OP_SREAD:   begin
                                store_rd = 1'b1;
                                resp     = mem[store_addr];
                            end
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt      <= '0;
            store_addr    <= '0;
            store_wen     <= 1'b0;
            baud_div      <= '0;
            wdog_period   <= '0;
            sys_reset_req <= 1'b0;
            for (int i = 0; i < STORE_DEPTH; i++) mem[i] <= '0;
        end else begin
            sys_reset_req <= 1'b0;
            if (store_wr)          busy_cnt <= CW'(BUSY_CYC);
            else if (store_busy)   busy_cnt <= busy_cnt - 1'b1;
            if (store_wr) mem[store_addr] <= data;
            if (store_wr || store_rd) store_addr <= store_addr + 1'b1;
            if (exec) begin
                case (cmd)
                    OP_BAUD:   baud_div    <= data;
                    OP_WDOG:   wdog_period <= data;
                    OP_SADDR:  store_addr  <= data[AW-1:0];
                    OP_SWEN:   store_wen   <= (data == KEY_WEN);
                    OP_SYSRST: if (data == KEY_RST) begin
                                   sys_reset_req <= 1'b1;
                                   store_wen     <= 1'b0;
                               end
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter logic [7:0] VERSION    = 8'h13,
    parameter int         BUSY_CYC   = 1250000,
    parameter int         FIFO_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [2:0] mode_pins,
    input  logic       wdog_reset_flag,
    output logic [7:0] ser_tx_data,
    output logic       ser_tx_avail,
    input  logic       ser_tx_take,
    input  logic [7:0] ser_rx_data,
    input  logic       ser_rx_put,
    output logic [7:0] baud_div,
    output logic [7:0] wdog_period,
    output logic       sys_reset_req
);
    logic       done;
    logic [7:0] rx_byte, load_byte, cmd_q, resp;
    slot_e      slot;
    logic [1:0] sync_run;
    logic       resync, exec;
    logic       tx_push, tx_empty, tx_full;
    logic       rx_pop, rx_empty, rx_full;
    logic [7:0] rx_head;
    logic       flush, overrun;
    logic       store_wr, store_busy, store_wen;
    logic [6:0] store_addr;
    logic [1:0] byte_pos;
    status_t    status_now;

    spi_byte_link u_link (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .load_byte(load_byte), .miso(spi_miso), .done(done), .rx_byte(rx_byte)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(rx_byte), .pop(ser_tx_take),
        .flush(flush), .rdata(ser_tx_data), .empty(tx_empty), .full(tx_full)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst), .push(ser_rx_put), .wdata(ser_rx_data), .pop(rx_pop),
        .flush(flush), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_cmd_engine #(.VERSION(VERSION), .BUSY_CYC(BUSY_CYC), .STORE_DEPTH(128)) u_eng (
        .clk(clk), .rst(rst), .exec(exec), .cmd(cmd_q), .data(rx_byte), .mode(mode_pins),
        .rx_head(rx_head), .rx_empty(rx_empty), .tx_full(tx_full), .resp(resp),
        .tx_push(tx_push), .rx_pop(rx_pop), .flush(flush), .baud_div(baud_div),
        .wdog_period(wdog_period), .sys_reset_req(sys_reset_req), .store_wr(store_wr),
        .store_busy(store_busy), .store_wen(store_wen), .store_addr(store_addr)
    );

    assign ser_tx_avail = !tx_empty;
    assign status_now   = pack_status(rx_empty, tx_full, overrun, store_busy, wdog_reset_flag);
    assign exec         = done && (slot == SLOT_DATA);
    assign resync       = done && (rx_byte == SYNC_BYTE) && (sync_run == 2'd2);
    assign byte_pos     = slot;

    always_comb begin
        load_byte = status_now;
        if (!resync) begin
            case (slot)
                SLOT_CMD:  load_byte = rx_byte;
                SLOT_DATA: load_byte = resp;
                default:   load_byte = status_now;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= SLOT_CMD;
            sync_run <= '0;
            cmd_q    <= '0;
            overrun  <= 1'b0;
        end else begin
            if (flush)                      overrun <= 1'b0;
            else if (ser_rx_put && rx_full) overrun <= 1'b1;
            if (done) begin
                if (slot == SLOT_CMD) cmd_q <= rx_byte;
                if (resync) begin
                    sync_run <= '0;
                    slot     <= SLOT_CMD;
                end else begin
                    sync_run <= (rx_byte == SYNC_BYTE) ? sync_run + 2'd1 : 2'd0;
                    case (slot)
                        SLOT_CMD:  slot <= SLOT_DATA;
                        SLOT_DATA: slot <= SLOT_TAIL;
                        default:   slot <= SLOT_CMD;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       store_wr,
    input logic       store_busy,
    input logic [6:0] store_addr,
    input logic [1:0] byte_pos,
    input logic       sys_reset_req
);
    // R10
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        store_wr |=> store_busy);

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        store_wr |=> store_addr == 7'($past(store_addr) + 7'd1));

    // R12
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> !sys_reset_req);

    // R13
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        byte_pos != 2'd3);
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk(clk), .rst(rst), .store_wr(store_wr), .store_busy(store_busy),
    .store_addr(store_addr), .byte_pos(byte_pos), .sys_reset_req(sys_reset_req)
);

// File: tb/spi_cmd_slave_test.sv
module spi_cmd_slave_test;
    localparam int         HALF = 8;
    localparam int         BUSY = 700;
    localparam logic [7:0] VER  = 8'h13;

    logic clk = 0, rst = 1;
    logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0, spi_miso;
    logic [2:0] mode_pins = 3'd0;
    logic wdog_reset_flag = 0;
    logic [7:0] ser_tx_data, ser_rx_data = 0, baud_div, wdog_period;
    logic ser_tx_avail, ser_tx_take = 0, ser_rx_put = 0, sys_reset_req;

    spi_cmd_slave #(.VERSION(VER), .BUSY_CYC(BUSY), .FIFO_DEPTH(32)) uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mode_pins(mode_pins),
        .wdog_reset_flag(wdog_reset_flag), .ser_tx_data(ser_tx_data),
        .ser_tx_avail(ser_tx_avail), .ser_tx_take(ser_tx_take),
        .ser_rx_data(ser_rx_data), .ser_rx_put(ser_rx_put), .baud_div(baud_div),
        .wdog_period(wdog_period), .sys_reset_req(sys_reset_req)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, pulses = 0, pulses_exp = 0;
    bit finished = 0;

    logic [7:0] mem_m [128];
    logic [6:0] addr_m;
    bit wen_m, acc_prev, ovr_m;
    logic [7:0] txq[$], rxq[$];
    logic [7:0] status_m;
    logic [7:0] baud_m, wdog_m;

    always @(posedge clk) if (!rst && sys_reset_req) pulses++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_stat(input bit busy);
        return {wdog_reset_flag, busy, 1'b0, ovr_m, 2'b00,
                (txq.size() < 32), (rxq.size() != 0)};
    endfunction

    function automatic string req_of(input logic [7:0] c);
        case (c)
            8'h01: return "R5";
            8'h02: return "R6";
            8'h05, 8'h06, 8'h0D: return "R8";
            8'h08: return "R7";
            8'h09: return "R9";
            8'h0A: return "R12";
            8'h0B: return "R11";
            8'h0F: return "R13";
            default: return "R4";
        endcase
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1;
            rx[i] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sclk = 0;
        end
    endtask

    task automatic session(input int n, input logic [7:0] b0, b1, b2,
                           output logic [7:0] r0, r1, r2);
        spi_cs_n = 0;
        repeat (HALF) @(negedge clk);
        xfer(b0, r0);
        if (n > 1) xfer(b1, r1);
        if (n > 2) xfer(b2, r2);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic idle_long();
        repeat (BUSY + 300) @(negedge clk);
        acc_prev = 0;
    endtask

    task automatic do_cmd(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r0, r1, r2, e_resp;
        bit acc;
        acc = 0;
        e_resp = 8'h00;
        case (c)
            8'h01: if (txq.size() < 32) txq.push_back(d);
            8'h02: if (rxq.size() != 0) e_resp = rxq.pop_front();
            8'h03: e_resp = VER;
            8'h04: baud_m = d;
            8'h05: addr_m = d[6:0];
            8'h06: if (wen_m && !acc_prev) begin
                       mem_m[addr_m] = d;
                       addr_m = addr_m + 7'd1;
                       acc = 1;
                   end
            8'h07: wdog_m = d;
            8'h08: begin txq.delete(); rxq.delete(); ovr_m = 0; end
            8'h09: wen_m = (d == 8'h42);
            8'h0A: if (d == 8'hC4) begin wen_m = 0; pulses_exp++; end
            8'h0B: e_resp = 8'hA0 | {5'b0, mode_pins};
            8'h0D: begin e_resp = mem_m[addr_m]; addr_m = addr_m + 7'd1; end
            default: ;
        endcase
        session(3, c, d, 8'h00, r0, r1, r2);
        chk("R2 status", r0, status_m);
        chk("R1 echo", r1, c);
        chk(req_of(c), r2, e_resp);
        status_m = mk_stat(acc || acc_prev);
        acc_prev = acc;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        ser_rx_data = b;
        ser_rx_put = 1;
        if (rxq.size() < 32) rxq.push_back(b); else ovr_m = 1;
        @(negedge clk);
        ser_rx_put = 0;
    endtask

    task automatic tx_pop();
        @(negedge clk);
        chk("R5 avail", {7'b0, ser_tx_avail}, {7'b0, txq.size() != 0});
        if (txq.size() != 0) begin
            chk("R5 order", ser_tx_data, txq.pop_front());
            ser_tx_take = 1;
            @(negedge clk);
            ser_tx_take = 0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1, r2, c, d;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
        addr_m = 0; wen_m = 0; acc_prev = 0; ovr_m = 0; status_m = 8'h00;
        baud_m = 0; wdog_m = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        chk("R2 reset miso", {7'b0, spi_miso}, 8'h00);
        chk("R5 reset avail", {7'b0, ser_tx_avail}, 8'h00);
        chk("R4 reset baud", baud_div, 8'h00);
        chk("R12 reset req", {7'b0, sys_reset_req}, 8'h00);

        // R2 first status is zero, R4 version, baud and watchdog period
        do_cmd(8'h03, 8'h00);
        do_cmd(8'h04, 8'h5A);
        chk("R4 baud", baud_div, 8'h5A);
        do_cmd(8'h07, 8'hC3);
        chk("R4 wdog", wdog_period, 8'hC3);
        // R4 unused codes
        do_cmd(8'h0C, 8'h11); do_cmd(8'h0E, 8'h22); do_cmd(8'h10, 8'h33); do_cmd(8'hFF, 8'h44);

        // R5 fill transmit queue, 33rd dropped
        for (int i = 0; i < 33; i++) do_cmd(8'h01, 8'(i * 7 + 3));
        do_cmd(8'h00, 8'h00);
        for (int i = 0; i < 33; i++) tx_pop();

        // R6 receive queue overrun, R3 status bits, R7 flush
        wdog_reset_flag = 1;
        for (int i = 0; i < 33; i++) rx_push(8'(i + 8'h40));
        do_cmd(8'h00, 8'h00);
        do_cmd(8'h02, 8'h00);
        do_cmd(8'h02, 8'h00);
        do_cmd(8'h08, 8'h00);
        do_cmd(8'h02, 8'h00);
        do_cmd(8'h00, 8'h00);
        wdog_reset_flag = 0;

        // R9 write key, R10 busy, R8 wrap
        do_cmd(8'h09, 8'h41);
        do_cmd(8'h05, 8'h7E);
        do_cmd(8'h06, 8'h99);
        do_cmd(8'h09, 8'h42);
        do_cmd(8'h06, 8'h11);
        do_cmd(8'h06, 8'h22);
        do_cmd(8'h06, 8'h33);
        idle_long();
        do_cmd(8'h06, 8'h44);
        idle_long();
        do_cmd(8'h05, 8'hFE);
        do_cmd(8'h0D, 8'h00); do_cmd(8'h0D, 8'h00); do_cmd(8'h0D, 8'h00); do_cmd(8'h0D, 8'h00);

        // R12 keyed reset request, R9 clears write enable
        do_cmd(8'h0A, 8'h11);
        chk("R12 no pulse", 8'(pulses), 8'(pulses_exp));
        do_cmd(8'h0A, 8'hC4);
        chk("R12 one pulse", 8'(pulses), 8'(pulses_exp));
        do_cmd(8'h05, 8'h10);
        do_cmd(8'h06, 8'h77);
        do_cmd(8'h05, 8'h10);
        do_cmd(8'h0D, 8'h00);

        // R11 mode readback
        mode_pins = 3'd0; do_cmd(8'h0B, 8'h00);
        mode_pins = 3'd5; do_cmd(8'h0B, 8'h00);
        mode_pins = 3'd7; do_cmd(8'h0B, 8'h00);

        // R13 resync from a misaligned position
        session(1, 8'h00, 8'h00, 8'h00, r0, r1, r2);
        session(3, 8'h0F, 8'h0F, 8'h0F, r0, r1, r2);
        status_m = mk_stat(acc_prev);
        acc_prev = 0;
        do_cmd(8'h03, 8'h00);

        // constrained random mix
        for (int n = 0; n < 150; n++) begin
            case ($urandom % 12)
                0: c = 8'h01;
                1: c = 8'h02;
                2: c = 8'h03;
                3: c = 8'h05;
                4: c = 8'h06;
                5: c = 8'h09;
                6: c = 8'h0B;
                7: c = 8'h0D;
                8: c = (($urandom % 4) == 0) ? 8'h08 : 8'h02;
                9: c = 8'(($urandom % 2) ? 8'h0C : 8'h0E);
                10: c = 8'(8'h10 + ($urandom % 8'hEF));
                default: c = 8'h04;
            endcase
            d = 8'($urandom);
            if (c == 8'h09 && ($urandom % 2)) d = 8'h42;
            mode_pins = 3'($urandom);
            wdog_reset_flag = 1'($urandom);
            do_cmd(c, d);
            if (acc_prev) idle_long();
            for (int k = 0; k < int'($urandom % 3); k++) rx_push(8'($urandom));
            if ($urandom % 3 == 0) tx_pop();
        end
        chk("R4 baud final", baud_div, baud_m);
        chk("R4 wdog final", wdog_period, wdog_m);
        chk("R12 pulse total", 8'(pulses), 8'(pulses_exp));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule